// File: doc/BRIEF.md
# Multi-core interrupt routing controller

This block sits between the interrupt sources of a four-core processor cluster and the cores themselves. Each core has four local timer interrupt lines and four mailbox-pending flags. A shared upstream IRQ and a shared upstream FIQ also arrive. The block steers every source to exactly one level output per core, either the IRQ output or the FIQ output, or masks it. Software sets up the steering through a small 32-bit register bank. It reads back per-core source words that show which sources are currently asserting each core's IRQ or FIQ.

Every local source of a core has two enable bits, one for IRQ and one for FIQ. When both are set, FIQ wins. A single routing register picks the core that receives the shared IRQ. A separate field picks the core that receives the shared FIQ, so the two can land on different cores. The status words and the outputs are combinational in the registered settings and the live input levels. A change on an input shows at the outputs in the same cycle, and a register write shows in the cycle after its clock edge.

The register bus accepts an access in every cycle in which `bus_valid` is high. It has no ready signal, so it never applies back-pressure and no transfer ever waits. The interrupt inputs and outputs are plain levels.

Top module: `irq_route_ctrl`

## Requirements
- R1: Reset (synchronous, active high) clears both routing fields, all timer control registers and all mailbox control registers. After reset every IRQ and FIQ output is low, and every register reads zero.
- R2: The timer control register of core c is at byte offset 0x40+4c and keeps only bits [7:0] of a write. Bit n (n=0..3) sends timer source n of that core to IRQ, and bit n+4 sends it to FIQ. Timer source n of core c is input bit `timer_irq[4c+n]`. The source appears at bit n of the status words.
- R3: A source whose FIQ and IRQ enables are both set is delivered as FIQ only. A source with neither enable set reaches neither output.
- R4: The mailbox control register of core c is at 0x50+4c, keeps bits [7:0], and uses the same IRQ/FIQ encoding as R2 for mailbox flag n of that core (`mbox_pend[4c+n]`). The flag appears at status bit 4+n.
- R5: The routing register at 0x0C holds, in bits [1:0], the core that receives the shared IRQ and, in bits [3:2], the core that receives the shared FIQ. It reads back as {28'b0, fiq_sel, irq_sel}. The shared interrupt appears at bit 8 of that core's IRQ or FIQ status word.
- R6: The IRQ status word of core c reads at 0x60+4c and the FIQ status word at 0x70+4c. Bits 9 to 31 read zero, and writes to these offsets change nothing.
- R7: A core's IRQ output is high exactly when its IRQ status word is nonzero, and likewise for FIQ. It follows input levels with no register in the path.
- R8: A read of an unmapped or unaligned offset returns zero, and a write there changes no register.
- R9: Read data is registered. `bus_rdata` takes the addressed value at the clock edge that accepts the read, and holds it until the next read, whatever writes occur in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| timer_irq | input | 16 | Local timer levels, bit 4c+n is source n of core c |
| mbox_pend | input | 16 | Mailbox-pending levels, bit 4c+n is mailbox n of core c |
| shared_irq | input | 1 | Shared upstream IRQ level |
| shared_fiq | input | 1 | Shared upstream FIQ level |
| bus_valid | input | 1 | Access request, accepted in the same cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_out | output | 4 | Per-core IRQ level |
| fiq_out | output | 4 | Per-core FIQ level |

## Verification
The outputs and status words are combinational, so a change on an interrupt input is checked in the same cycle, half a period after it is driven. A register write takes effect at the edge that accepts it, and its effect on `irq_out`/`fiq_out` is sampled at the falling edge that follows. Read data is due exactly one edge after the request. The bench drives a read on a falling edge and samples `bus_rdata` on the next falling edge. One scenario probes just after the accepting edge and just before it, to pin the latency to one cycle and to show that the value holds afterwards.

// File: rtl/irq_route_pkg.sv
`timescale 1ns/1ps
package irq_route_pkg;
  localparam int STAT_W   = 32;  // status word width
  localparam int ROUTE_W  = 2;   // width of each routing field
  localparam int LOCAL_N  = 4;   // local sources of each kind per core
  localparam int CTL_W    = 2 * LOCAL_N;  // IRQ enables low, FIQ enables high
  localparam int MB_BASE  = LOCAL_N;      // first mailbox status bit
  localparam int SH_BIT   = 2 * LOCAL_N;  // shared interrupt status bit
  // word indices (byte offset / 4)
  localparam logic [5:0] W_ROUTE = 6'h03;
  localparam logic [3:0] G_TCTL  = 4'h4;
  localparam logic [3:0] G_MCTL  = 4'h5;
  localparam logic [3:0] G_IRQW  = 4'h6;
  localparam logic [3:0] G_FIQW  = 4'h7;
endpackage

// File: rtl/irq_route_regs.sv
`timescale 1ns/1ps
module irq_route_regs
  import irq_route_pkg::*;
#(
  parameter int NCORES = 4,
  parameter int ADDR_W = 8
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             bus_valid,
  input  logic                             bus_we,
  input  logic [ADDR_W-1:0]                bus_addr,
  input  logic [31:0]                      bus_wdata,
  input  logic [NCORES-1:0][STAT_W-1:0]    irq_w,
  input  logic [NCORES-1:0][STAT_W-1:0]    fiq_w,
  output logic [ROUTE_W-1:0]               route_irq,
  output logic [ROUTE_W-1:0]               route_fiq,
  output logic [NCORES-1:0][CTL_W-1:0]     tctl,
  output logic [NCORES-1:0][CTL_W-1:0]     mctl,
  output logic [31:0]                      bus_rdata
);
  localparam int IDX_W = 2;

  logic [ADDR_W-3:0] word;
  logic [3:0]        grp;
  logic [IDX_W-1:0]  idx;
  logic              aligned, idx_ok;
  logic              hit_route, hit_tctl, hit_mctl, hit_irqw, hit_fiqw;
  logic [31:0]       rd_next;
  logic [31:0]       unused_wdata;

  assign unused_wdata = bus_wdata;
  assign word    = bus_addr[ADDR_W-1:2];
  assign grp     = word[5:2];
  assign idx     = word[IDX_W-1:0];
  assign aligned = (bus_addr[1:0] == 2'b00) && (word[ADDR_W-3:6] == '0);
  assign idx_ok  = int'(idx) < NCORES;

  assign hit_route = aligned && (word[5:0] == W_ROUTE);
  assign hit_tctl  = aligned && (grp == G_TCTL) && idx_ok;
  assign hit_mctl  = aligned && (grp == G_MCTL) && idx_ok;
  assign hit_irqw  = aligned && (grp == G_IRQW) && idx_ok;
  assign hit_fiqw  = aligned && (grp == G_FIQW) && idx_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      route_irq <= '0;
      route_fiq <= '0;
      tctl      <= '0;
      mctl      <= '0;
    end else if (bus_valid && bus_we) begin
      if (hit_route) begin
        route_irq <= bus_wdata[ROUTE_W-1:0];
        route_fiq <= bus_wdata[2*ROUTE_W-1:ROUTE_W];
      end
      if (hit_tctl) tctl[idx] <= bus_wdata[CTL_W-1:0];
      if (hit_mctl) mctl[idx] <= bus_wdata[CTL_W-1:0];
    end
  end

  always_comb begin
    rd_next = '0;
    if (hit_route)     rd_next = 32'({route_fiq, route_irq});
    else if (hit_tctl) rd_next = 32'(tctl[idx]);
    else if (hit_mctl) rd_next = 32'(mctl[idx]);
    else if (hit_irqw) rd_next = irq_w[idx];
    else if (hit_fiqw) rd_next = fiq_w[idx];
  end

  always_ff @(posedge clk) begin
    if (rst)                        bus_rdata <= '0;
    else if (bus_valid && !bus_we)  bus_rdata <= rd_next;
  end
endmodule

// File: rtl/irq_route_core.sv
`timescale 1ns/1ps
module irq_route_core
  import irq_route_pkg::*;
#(
  parameter int CORE_ID = 0
) (
  input  logic [LOCAL_N-1:0] timer,
  input  logic [LOCAL_N-1:0] mbox,
  input  logic [CTL_W-1:0]   tctl,
  input  logic [CTL_W-1:0]   mctl,
  input  logic               shared_irq,
  input  logic               shared_fiq,
  input  logic [ROUTE_W-1:0] route_irq,
  input  logic [ROUTE_W-1:0] route_fiq,
  output logic [STAT_W-1:0]  irq_w,
  output logic [STAT_W-1:0]  fiq_w,
  output logic               irq_o,
  output logic               fiq_o
);
  localparam logic [ROUTE_W-1:0] ME = ROUTE_W'(CORE_ID);

  always_comb begin
    irq_w = '0;
    fiq_w = '0;
    for (int n = 0; n < LOCAL_N; n++) begin
      // FIQ enable overrides IRQ enable
      fiq_w[n]         = timer[n] && tctl[n+LOCAL_N];
      irq_w[n]         = timer[n] && tctl[n] && !tctl[n+LOCAL_N];
      fiq_w[MB_BASE+n] = mbox[n] && mctl[n+LOCAL_N];
      irq_w[MB_BASE+n] = mbox[n] && mctl[n] && !mctl[n+LOCAL_N];
    end
    irq_w[SH_BIT] = shared_irq && (route_irq == ME);
    fiq_w[SH_BIT] = shared_fiq && (route_fiq == ME);
  end

  assign irq_o = |irq_w;
  assign fiq_o = |fiq_w;
endmodule

// File: rtl/irq_route_ctrl.sv
`timescale 1ns/1ps
module irq_route_ctrl
  import irq_route_pkg::*;
#(
  parameter int NCORES = 4,
  parameter int ADDR_W = 8,
  localparam int SRC_W = NCORES * LOCAL_N
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SRC_W-1:0]  timer_irq,
  input  logic [SRC_W-1:0]  mbox_pend,
  input  logic              shared_irq,
  input  logic              shared_fiq,
  input  logic              bus_valid,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [NCORES-1:0] irq_out,
  output logic [NCORES-1:0] fiq_out
);
  logic [ROUTE_W-1:0]            route_irq, route_fiq;
  logic [NCORES-1:0][CTL_W-1:0]  tctl, mctl;
  logic [NCORES-1:0][STAT_W-1:0] irq_w, fiq_w;

  irq_route_regs #(.NCORES(NCORES), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst),
    .bus_valid(bus_valid), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .irq_w(irq_w), .fiq_w(fiq_w),
    .route_irq(route_irq), .route_fiq(route_fiq),
    .tctl(tctl), .mctl(mctl), .bus_rdata(bus_rdata)
  );

  for (genvar c = 0; c < NCORES; c++) begin : g_core
    irq_route_core #(.CORE_ID(c)) u_core (
      .timer(timer_irq[c*LOCAL_N +: LOCAL_N]),
      .mbox(mbox_pend[c*LOCAL_N +: LOCAL_N]),
      .tctl(tctl[c]), .mctl(mctl[c]),
      .shared_irq(shared_irq), .shared_fiq(shared_fiq),
      .route_irq(route_irq), .route_fiq(route_fiq),
      .irq_w(irq_w[c]), .fiq_w(fiq_w[c]),
      .irq_o(irq_out[c]), .fiq_o(fiq_out[c])
    );
  end
endmodule

// File: rtl/irq_route_chk.sv
`timescale 1ns/1ps
module irq_route_chk
  import irq_route_pkg::*;
#(
  parameter int NCORES = 4,
  parameter int ADDR_W = 8,
  localparam int SRC_W = NCORES * LOCAL_N
) (
  input logic                          clk,
  input logic                          rst,
  input logic [SRC_W-1:0]              timer_irq,
  input logic [SRC_W-1:0]              mbox_pend,
  input logic                          shared_irq,
  input logic                          shared_fiq,
  input logic                          bus_valid,
  input logic                          bus_we,
  input logic [ADDR_W-1:0]             bus_addr,
  input logic [31:0]                   bus_rdata,
  input logic [NCORES-1:0]             irq_out,
  input logic [NCORES-1:0]             fiq_out,
  input logic [ROUTE_W-1:0]            route_irq,
  input logic [ROUTE_W-1:0]            route_fiq,
  input logic [NCORES-1:0][CTL_W-1:0]  tctl,
  input logic [NCORES-1:0][CTL_W-1:0]  mctl,
  input logic [NCORES-1:0][STAT_W-1:0] irq_w,
  input logic [NCORES-1:0][STAT_W-1:0] fiq_w
);
  logic no_reg_hit;
  assign no_reg_hit = (bus_addr < ADDR_W'(8'h0C)) ||
                      ((bus_addr > ADDR_W'(8'h0C)) && (bus_addr < ADDR_W'(8'h40))) ||
                      (bus_addr >= ADDR_W'(8'h60));

  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (route_irq == '0 && route_fiq == '0 && tctl == '0 && mctl == '0));

  a_r9_route_read: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !bus_we && bus_addr == ADDR_W'(8'h0C)) |=>
      bus_rdata == 32'({$past(route_fiq), $past(route_irq)}));

  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    !(bus_valid && !bus_we) |=> $stable(bus_rdata));

  a_r8_stray_write: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && bus_we && no_reg_hit) |=>
      ($stable(route_irq) && $stable(route_fiq) && $stable(tctl) && $stable(mctl)));

  a_r7_quiet: assert property (@(posedge clk) disable iff (rst)
    (timer_irq == '0 && mbox_pend == '0 && !shared_irq && !shared_fiq) |->
      (irq_out == '0 && fiq_out == '0));

  for (genvar c = 0; c < NCORES; c++) begin : g_c
    a_r3_exclusive: assert property (@(posedge clk) disable iff (rst)
      (irq_w[c][SH_BIT-1:0] & fiq_w[c][SH_BIT-1:0]) == '0);
    a_r6_upper_zero: assert property (@(posedge clk) disable iff (rst)
      (irq_w[c][STAT_W-1:SH_BIT+1] == '0) && (fiq_w[c][STAT_W-1:SH_BIT+1] == '0));
  end
endmodule

bind irq_route_ctrl irq_route_chk #(.NCORES(NCORES), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .timer_irq(timer_irq), .mbox_pend(mbox_pend),
  .shared_irq(shared_irq), .shared_fiq(shared_fiq),
  .bus_valid(bus_valid), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .irq_out(irq_out), .fiq_out(fiq_out),
  .route_irq(route_irq), .route_fiq(route_fiq), .tctl(tctl), .mctl(mctl),
  .irq_w(irq_w), .fiq_w(fiq_w)
);

// File: tb/sim_irq_route_ctrl.sv
`timescale 1ns/1ps
module sim_irq_route_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] timer_irq = '0;
  logic [15:0] mbox_pend = '0;
  logic        shared_irq = 1'b0, shared_fiq = 1'b0;
  logic        bus_valid = 1'b0, bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  irq_out, fiq_out;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irq_route_ctrl u0 (
    .clk(clk), .rst(rst), .timer_irq(timer_irq), .mbox_pend(mbox_pend),
    .shared_irq(shared_irq), .shared_fiq(shared_fiq),
    .bus_valid(bus_valid), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_out(irq_out), .fiq_out(fiq_out)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0;
    d = bus_rdata;
  endtask

  task automatic quiet();
    @(negedge clk);
    timer_irq = '0; mbox_pend = '0; shared_irq = 1'b0; shared_fiq = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 irq_out after reset", 32'(irq_out), 32'h0);
    chk("R1 fiq_out after reset", 32'(fiq_out), 32'h0);
    rd(8'h0C, d); chk("R1 route reg", d, 32'h0);
    rd(8'h4C, d); chk("R1 timer ctl core3", d, 32'h0);
    rd(8'h50, d); chk("R1 mailbox ctl core0", d, 32'h0);
  endtask

  task automatic t_timer();
    logic [31:0] d;
    wr(8'h44, 32'hFFFF_FF01);
    rd(8'h44, d); chk("R2 low byte kept", d, 32'h0000_0001);
    wr(8'h44, 32'h0000_0001);
    @(negedge clk); timer_irq[4] = 1'b1;
    #1 chk("R7 irq_out same cycle", 32'(irq_out), 32'h2);
    chk("R2 fiq_out for IRQ-enabled source", 32'(fiq_out), 32'h0);
    rd(8'h64, d); chk("R2 core1 irq word", d, 32'h1);
    wr(8'h40, 32'h0000_0020);
    @(negedge clk); timer_irq[1] = 1'b1;
    #1 chk("R2 core0 FIQ for source1", 32'(fiq_out), 32'h1);
    rd(8'h70, d); chk("R6 core0 fiq word", d, 32'h2);
    quiet();
  endtask

  task automatic t_prec();
    logic [31:0] d;
    @(negedge clk); timer_irq[4] = 1'b1;
    wr(8'h44, 32'h0000_0011);
    chk("R3 both set: FIQ", 32'(fiq_out), 32'h2);
    chk("R3 both set: no IRQ", 32'(irq_out), 32'h0);
    rd(8'h64, d); chk("R3 irq word empty", d, 32'h0);
    rd(8'h74, d); chk("R3 fiq word bit0", d, 32'h1);
    wr(8'h44, 32'h0);
    chk("R3 masked irq", 32'(irq_out), 32'h0);
    chk("R3 masked fiq", 32'(fiq_out), 32'h0);
    quiet();
  endtask

  task automatic t_mbox();
    logic [31:0] d;
    wr(8'h58, 32'h0000_0084);
    @(negedge clk); mbox_pend[10] = 1'b1;
    #1 chk("R4 mailbox2 to IRQ", 32'(irq_out), 32'h4);
    rd(8'h68, d); chk("R4 status bit6", d, 32'h40);
    @(negedge clk); mbox_pend[11] = 1'b1;
    #1 chk("R4 mailbox3 to FIQ", 32'(fiq_out), 32'h4);
    rd(8'h78, d); chk("R4 status bit7", d, 32'h80);
    rd(8'h58, d); chk("R4 readback", d, 32'h84);
    quiet();
  endtask

  task automatic t_route();
    logic [31:0] d;
    wr(8'h0C, 32'h0000_000B);
    rd(8'h0C, d); chk("R5 readback", d, 32'hB);
    @(negedge clk); shared_irq = 1'b1;
    #1 chk("R5 shared IRQ to core3", 32'(irq_out), 32'h8);
    rd(8'h6C, d); chk("R5 core3 bit8", d, 32'h100);
    @(negedge clk); shared_fiq = 1'b1;
    #1 chk("R5 shared FIQ to core2", 32'(fiq_out), 32'h4);
    rd(8'h78, d); chk("R5 core2 fiq bit8", d, 32'h100);
    wr(8'h0C, 32'h0000_0004);
    chk("R5 shared IRQ to core0", 32'(irq_out), 32'h1);
    chk("R5 shared FIQ to core1", 32'(fiq_out), 32'h2);
    quiet();
  endtask

  task automatic t_status_ro();
    logic [31:0] d;
    @(negedge clk); shared_irq = 1'b1;
    wr(8'h60, 32'hFFFF_FFFF);
    wr(8'h70, 32'hFFFF_FFFF);
    rd(8'h60, d); chk("R6 irq word unchanged", d, 32'h100);
    rd(8'h70, d); chk("R6 fiq word unchanged", d, 32'h0);
    rd(8'h0C, d); chk("R6 route untouched", d, 32'h4);
    quiet();
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    wr(8'h40, 32'h0000_0003);
    wr(8'h00, 32'hFFFF_FFFF);
    wr(8'h20, 32'hFFFF_FFFF);
    wr(8'h90, 32'hFFFF_FFFF);
    wr(8'h41, 32'hFFFF_FFFF);
    wr(8'h0D, 32'hFFFF_FFFF);
    rd(8'h40, d); chk("R8 timer ctl untouched", d, 32'h3);
    rd(8'h0C, d); chk("R8 route untouched", d, 32'h4);
    rd(8'h20, d); chk("R8 unmapped read zero", d, 32'h0);
    rd(8'h40, d);
    rd(8'h41, d); chk("R8 unaligned read zero", d, 32'h0);
  endtask

  task automatic t_latency();
    logic [31:0] d;
    rd(8'h20, d);
    @(negedge clk);
    bus_valid = 1'b1; bus_we = 1'b0; bus_addr = 8'h0C;
    #1 chk("R9 old data before edge", bus_rdata, 32'h0);
    @(posedge clk); #1;
    chk("R9 data one edge later", bus_rdata, 32'h4);
    @(negedge clk); bus_valid = 1'b0;
    wr(8'h0C, 32'h0);
    @(negedge clk); @(negedge clk);
    chk("R9 data held across write", bus_rdata, 32'h4);
  endtask

  task automatic t_reset_again();
    logic [31:0] d;
    wr(8'h0C, 32'hF); wr(8'h4C, 32'hFF); wr(8'h54, 32'hFF);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    rd(8'h0C, d); chk("R1 route cleared", d, 32'h0);
    rd(8'h4C, d); chk("R1 timer ctl cleared", d, 32'h0);
    rd(8'h54, d); chk("R1 mailbox ctl cleared", d, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_timer();
    t_prec();
    t_mbox();
    t_route();
    t_status_ro();
    t_unmapped();
    t_latency();
    t_reset_again();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule